// File: doc/BRIEF.md
# Paged Memory Mapper Register File

The block widens a 16-bit processor address into a 19-bit physical address, so that a 64 KB processor window can reach 512 KB of memory in 16 KB pages. Four page registers hold 5-bit page numbers. On each memory access, the two most significant processor address bits pick one register. That register's page number becomes the upper part of the physical address, and the fourteen low address bits pass through unchanged.

Software loads the registers through a block of four consecutive I/O ports, which start at port FCh by default. Only the low byte of the I/O address takes part in the decode. A build parameter selects whether the registers can also be read back through those ports. A build without read-back is still a working mapper; the read-back option exists for programs that read the registers. Memory timing, refresh and address multiplexing are handled outside this block. It delivers only a flat physical address and the I/O read data.

Top module: `page_mapper`

## Requirements
- R1: A synchronous reset loads the quarter registers 0, 1, 2 and 3 with page numbers 3, 2, 1 and 0.
- R2: `phys_addr` equals the page number held by register `cpu_addr[15:14]`, followed by `cpu_addr[13:0]` in bits 13:0. It follows `cpu_addr` in the same cycle.
- R3: When `io_wr` is high at a rising clock edge and the low I/O address byte is FCh+k (k = 0..3), register k takes the write data. The new page shows on `phys_addr` from that edge onward.
- R4: A register write keeps `io_wdata[4:0]`, and `io_wdata[7:5]` has no effect on the stored page.
- R5: The port decode looks only at `io_addr[7:0]`, so the upper address byte can hold any value. A write to a low byte outside FCh..FFh changes no register.
- R6: While `io_wr` is low, a decoded port address changes no register.
- R7: With read-back enabled, `io_rd` high at port FCh+k drives `io_rdata` = {3'b111, page of register k} and raises `io_rdata_oe` in the same cycle.
- R8: When no decoded read is present (`io_rd` low, or the port is outside FCh..FFh), `io_rdata_oe` is 0 and `io_rdata` is 00h.
- R9: When `READBACK_EN` is 0, `io_rdata_oe` stays 0 and `io_rdata` stays 00h for every input.
- R10: A read and a write to the same port in one cycle return the page held before that clock edge. The written value appears in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all register updates happen on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | Processor memory address |
| io_addr | input | 16 | Processor I/O address; only bits 7:0 are decoded |
| io_wr | input | 1 | I/O write strobe |
| io_rd | input | 1 | I/O read strobe |
| io_wdata | input | 8 | I/O write data |
| phys_addr | output | 19 | Physical memory address |
| io_rdata | output | 8 | Read-back data; 00h when not enabled |
| io_rdata_oe | output | 1 | High while a decoded read-back drives io_rdata |

## Verification
The translated address and the read-back data are combinational. The bench therefore drives each stimulus on the falling edge and compares both one nanosecond later, before the next rising edge. A register write is due exactly one rising edge after it is presented. The bench reference model applies the write only after that edge, so the compare made in the write's own cycle still expects the old page (R10). The next cycle's compare expects the new page. The write-only build shares every stimulus with the main instance and is compared in the same slot.

// File: rtl/pmap_pkg.sv
package pmap_pkg;

  // Width of the I/O address slice that takes part in port decode.
  localparam int IO_DEC_W = 8;

  // Page number loaded into a quarter register at reset: the highest
  // quarter gets page 0, the lowest gets the top page of the set.
  function automatic int boot_page(input int slot, input int num_slots);
    return num_slots - 1 - slot;
  endfunction

  // Number of constant-one fill bits above a page on read-back.
  function automatic int fill_width(input int data_w, input int page_w);
    return data_w - page_w;
  endfunction

endpackage

// File: rtl/pmap_io_decode.sv
module pmap_io_decode
  import pmap_pkg::*;
#(
  parameter int             IO_ADDR_W = 16,
  parameter logic [7:0]     IO_BASE   = 8'hFC,
  parameter int             SEL_W     = 2
) (
  input  logic [IO_ADDR_W-1:0] io_addr,
  input  logic                 io_wr,
  input  logic                 io_rd,
  output logic [SEL_W-1:0]     port_slot,
  output logic                 wr_fire,
  output logic                 rd_fire
);

  logic [IO_DEC_W-1:0] port_lo;
  logic [IO_DEC_W-1:0] port_off;
  logic                port_hit;

  assign port_lo   = io_addr[IO_DEC_W-1:0];
  // Distance from the base port; a hit leaves only the slot bits set.
  assign port_off  = port_lo - IO_BASE;
  assign port_hit  = (port_off[IO_DEC_W-1:SEL_W] == '0);
  assign port_slot = port_off[SEL_W-1:0];

  assign wr_fire = io_wr & port_hit;
  assign rd_fire = io_rd & port_hit;

  generate
    if (IO_ADDR_W > IO_DEC_W) begin : g_hi_ignored
      logic unused_hi_bits;
      assign unused_hi_bits = ^io_addr[IO_ADDR_W-1:IO_DEC_W];
    end
  endgenerate

endmodule

// File: rtl/pmap_page_bank.sv
module pmap_page_bank
  import pmap_pkg::*;
#(
  parameter int NUM_REGS = 4,
  parameter int PAGE_W   = 5,
  parameter int SEL_W    = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_fire,
  input  logic [SEL_W-1:0]           wr_slot,
  input  logic [PAGE_W-1:0]          wr_page,
  output logic [NUM_REGS*PAGE_W-1:0] pages_flat
);

  generate
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_quarter
      localparam logic [PAGE_W-1:0] BOOT_VAL = PAGE_W'(boot_page(g, NUM_REGS));
      localparam logic [SEL_W-1:0]  MY_SLOT  = SEL_W'(g);

      logic [PAGE_W-1:0] page_q;
      logic              load_me;

      assign load_me = wr_fire && (wr_slot == MY_SLOT);

      always_ff @(posedge clk) begin
        if (rst) begin
          page_q <= BOOT_VAL;
        end else if (load_me) begin
          page_q <= wr_page;
        end
      end

      assign pages_flat[g*PAGE_W +: PAGE_W] = page_q;
    end
  endgenerate

endmodule

// File: rtl/pmap_translate.sv
module pmap_translate #(
  parameter int CPU_ADDR_W = 16,
  parameter int OFFSET_W   = 14,
  parameter int PAGE_W     = 5,
  parameter int SEL_W      = 2,
  parameter int NUM_REGS   = 4
) (
  input  logic [CPU_ADDR_W-1:0]      cpu_addr,
  input  logic [NUM_REGS*PAGE_W-1:0] pages_flat,
  output logic [PAGE_W+OFFSET_W-1:0] phys_addr
);

  function automatic logic [PAGE_W-1:0] pick_page(
    input logic [NUM_REGS*PAGE_W-1:0] flat,
    input logic [SEL_W-1:0]           sel
  );
    return flat[int'(sel)*PAGE_W +: PAGE_W];
  endfunction

  logic [SEL_W-1:0]    quarter;
  logic [OFFSET_W-1:0] offset;

  assign quarter   = cpu_addr[CPU_ADDR_W-1 -: SEL_W];
  assign offset    = cpu_addr[OFFSET_W-1:0];
  assign phys_addr = {pick_page(pages_flat, quarter), offset};

endmodule

// File: rtl/pmap_readback.sv
module pmap_readback
  import pmap_pkg::*;
#(
  parameter int NUM_REGS    = 4,
  parameter int PAGE_W      = 5,
  parameter int SEL_W       = 2,
  parameter int DATA_W      = 8,
  parameter bit READBACK_EN = 1'b1
) (
  input  logic [NUM_REGS*PAGE_W-1:0] pages_flat,
  input  logic                       rd_fire,
  input  logic [SEL_W-1:0]           rd_slot,
  output logic [DATA_W-1:0]          io_rdata,
  output logic                       io_rdata_oe
);

  localparam int FILL_W = fill_width(DATA_W, PAGE_W);

  generate
    if (READBACK_EN) begin : g_readback
      logic [PAGE_W-1:0] sel_page;
      assign sel_page    = pages_flat[int'(rd_slot)*PAGE_W +: PAGE_W];
      assign io_rdata_oe = rd_fire;
      assign io_rdata    = rd_fire ? {{FILL_W{1'b1}}, sel_page} : '0;
    end else begin : g_write_only
      logic unused_rb_inputs;
      assign unused_rb_inputs = ^{pages_flat, rd_fire, rd_slot};
      assign io_rdata_oe = 1'b0;
      assign io_rdata    = '0;
    end
  endgenerate

endmodule

// File: rtl/page_mapper.sv
module page_mapper
  import pmap_pkg::*;
#(
  parameter int         CPU_ADDR_W  = 16,
  parameter int         OFFSET_W    = 14,
  parameter int         PAGE_W      = 5,
  parameter int         IO_ADDR_W   = 16,
  parameter int         DATA_W      = 8,
  parameter logic [7:0] IO_BASE     = 8'hFC,
  parameter bit         READBACK_EN = 1'b1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [CPU_ADDR_W-1:0]      cpu_addr,
  input  logic [IO_ADDR_W-1:0]       io_addr,
  input  logic                       io_wr,
  input  logic                       io_rd,
  input  logic [DATA_W-1:0]          io_wdata,
  output logic [PAGE_W+OFFSET_W-1:0] phys_addr,
  output logic [DATA_W-1:0]          io_rdata,
  output logic                       io_rdata_oe
);

  localparam int SEL_W    = CPU_ADDR_W - OFFSET_W;
  localparam int NUM_REGS = 1 << SEL_W;

  // Named internal events, visible to the bound checker.
  logic                       wr_fire;
  logic                       rd_fire;
  logic [SEL_W-1:0]           port_slot;
  logic [NUM_REGS*PAGE_W-1:0] pages_flat;
  logic [PAGE_W-1:0]          wr_page;
  logic                       unused_wdata_hi;

  assign wr_page         = io_wdata[PAGE_W-1:0];
  assign unused_wdata_hi = ^io_wdata[DATA_W-1:PAGE_W];

  pmap_io_decode #(
    .IO_ADDR_W (IO_ADDR_W),
    .IO_BASE   (IO_BASE),
    .SEL_W     (SEL_W)
  ) u_decode (
    .io_addr   (io_addr),
    .io_wr     (io_wr),
    .io_rd     (io_rd),
    .port_slot (port_slot),
    .wr_fire   (wr_fire),
    .rd_fire   (rd_fire)
  );

  pmap_page_bank #(
    .NUM_REGS (NUM_REGS),
    .PAGE_W   (PAGE_W),
    .SEL_W    (SEL_W)
  ) u_bank (
    .clk        (clk),
    .rst        (rst),
    .wr_fire    (wr_fire),
    .wr_slot    (port_slot),
    .wr_page    (wr_page),
    .pages_flat (pages_flat)
  );

  pmap_translate #(
    .CPU_ADDR_W (CPU_ADDR_W),
    .OFFSET_W   (OFFSET_W),
    .PAGE_W     (PAGE_W),
    .SEL_W      (SEL_W),
    .NUM_REGS   (NUM_REGS)
  ) u_translate (
    .cpu_addr   (cpu_addr),
    .pages_flat (pages_flat),
    .phys_addr  (phys_addr)
  );

  pmap_readback #(
    .NUM_REGS    (NUM_REGS),
    .PAGE_W      (PAGE_W),
    .SEL_W       (SEL_W),
    .DATA_W      (DATA_W),
    .READBACK_EN (READBACK_EN)
  ) u_readback (
    .pages_flat  (pages_flat),
    .rd_fire     (rd_fire),
    .rd_slot     (port_slot),
    .io_rdata    (io_rdata),
    .io_rdata_oe (io_rdata_oe)
  );

endmodule

// File: rtl/page_mapper_chk.sv
module page_mapper_chk #(
  parameter int         CPU_ADDR_W  = 16,
  parameter int         OFFSET_W    = 14,
  parameter int         PAGE_W      = 5,
  parameter int         IO_ADDR_W   = 16,
  parameter int         DATA_W      = 8,
  parameter logic [7:0] IO_BASE     = 8'hFC,
  parameter bit         READBACK_EN = 1'b1
) (
  input logic                                                clk,
  input logic                                                rst,
  input logic [CPU_ADDR_W-1:0]                               cpu_addr,
  input logic [IO_ADDR_W-1:0]                                io_addr,
  input logic                                                io_wr,
  input logic                                                io_rd,
  input logic [DATA_W-1:0]                                   io_wdata,
  input logic [PAGE_W+OFFSET_W-1:0]                          phys_addr,
  input logic [DATA_W-1:0]                                   io_rdata,
  input logic                                                io_rdata_oe,
  input logic [((1 << (CPU_ADDR_W-OFFSET_W))*PAGE_W)-1:0]    pages_flat,
  input logic                                                wr_fire
);

  localparam int SEL_W    = CPU_ADDR_W - OFFSET_W;
  localparam int NUM_REGS = 1 << SEL_W;
  localparam int FLAT_W   = NUM_REGS * PAGE_W;

  function automatic logic [PAGE_W-1:0] page_at(input logic [FLAT_W-1:0] f, input int s);
    return f[s*PAGE_W +: PAGE_W];
  endfunction

  function automatic logic [FLAT_W-1:0] boot_flat();
    logic [FLAT_W-1:0] f;
    f = '0;
    for (int i = 0; i < NUM_REGS; i++) f[i*PAGE_W +: PAGE_W] = PAGE_W'(NUM_REGS - 1 - i);
    return f;
  endfunction

  logic [7:0]       slot_off;
  logic             port_in;
  logic [SEL_W-1:0] slot;
  logic             port_wr;
  logic             unused_chk;

  assign slot_off   = io_addr[7:0] - IO_BASE;
  assign port_in    = slot_off < 8'(NUM_REGS);
  assign slot       = slot_off[SEL_W-1:0];
  assign port_wr    = io_wr && port_in;
  assign unused_chk = ^{io_addr, io_wdata};

  p_boot_pages_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> pages_flat == boot_flat());

  p_flat_map_r2: assert property (@(posedge clk) disable iff (rst)
    (phys_addr[OFFSET_W-1:0] == cpu_addr[OFFSET_W-1:0]) &&
    (phys_addr[PAGE_W+OFFSET_W-1:OFFSET_W] ==
       page_at(pages_flat, int'(cpu_addr[CPU_ADDR_W-1 -: SEL_W]))));

  p_write_lands_r3: assert property (@(posedge clk) disable iff (rst)
    port_wr |=> page_at(pages_flat, int'($past(slot))) == $past(io_wdata[PAGE_W-1:0]));

  p_other_ports_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !port_wr |=> $stable(pages_flat));

  p_fire_needs_strobe_r6: assert property (@(posedge clk) disable iff (rst)
    wr_fire |-> (io_wr && port_in));

  p_rdata_fill_r7: assert property (@(posedge clk) disable iff (rst)
    io_rdata_oe |-> io_rdata == {{(DATA_W-PAGE_W){1'b1}}, page_at(pages_flat, int'(slot))});

  p_oe_decoded_r8: assert property (@(posedge clk) disable iff (rst)
    io_rdata_oe |-> (io_rd && port_in));

  p_idle_bus_zero_r8: assert property (@(posedge clk) disable iff (rst)
    !io_rdata_oe |-> io_rdata == '0);

  p_write_only_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    !READBACK_EN |-> !io_rdata_oe);

endmodule

bind page_mapper page_mapper_chk #(
  .CPU_ADDR_W  (CPU_ADDR_W),
  .OFFSET_W    (OFFSET_W),
  .PAGE_W      (PAGE_W),
  .IO_ADDR_W   (IO_ADDR_W),
  .DATA_W      (DATA_W),
  .IO_BASE     (IO_BASE),
  .READBACK_EN (READBACK_EN)
) u_page_mapper_chk (
  .clk         (clk),
  .rst         (rst),
  .cpu_addr    (cpu_addr),
  .io_addr     (io_addr),
  .io_wr       (io_wr),
  .io_rd       (io_rd),
  .io_wdata    (io_wdata),
  .phys_addr   (phys_addr),
  .io_rdata    (io_rdata),
  .io_rdata_oe (io_rdata_oe),
  .pages_flat  (pages_flat),
  .wr_fire     (wr_fire)
);

// File: tb/page_mapper_bench.sv
module page_mapper_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [15:0] io_addr  = '0;
  logic        io_wr    = 1'b0;
  logic        io_rd    = 1'b0;
  logic [7:0]  io_wdata = '0;
  logic [18:0] phys_addr, phys_wo;
  logic [7:0]  io_rdata, rdata_wo;
  logic        io_rdata_oe, oe_wo;

  always #4 clk = ~clk;   // 125 MHz

  page_mapper u_page_mapper (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .io_addr(io_addr),
    .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata),
    .phys_addr(phys_addr), .io_rdata(io_rdata), .io_rdata_oe(io_rdata_oe)
  );

  page_mapper #(.READBACK_EN(1'b0)) u_page_mapper_wo (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .io_addr(io_addr),
    .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata),
    .phys_addr(phys_wo), .io_rdata(rdata_wo), .io_rdata_oe(oe_wo)
  );

  int ref_pg[4];
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int slot_of(input int ioa);
    int lo;
    lo = ioa & 8'hFF;
    return (lo >= 8'hFC) ? lo - 8'hFC : -1;
  endfunction

  // One clock: drive at the falling edge, compare combinational results
  // 1 ns later, then let the model take any write after the rising edge.
  task automatic step(input int cpu, input int ioa, input bit wr, input bit rd,
                      input int wd, input string req);
    int slot, exp_phys, exp_rd;
    bit exp_oe;
    @(negedge clk);
    cpu_addr = 16'(cpu); io_addr = 16'(ioa);
    io_wr = wr; io_rd = rd; io_wdata = 8'(wd);
    #1;
    slot     = slot_of(ioa);
    exp_phys = (ref_pg[(cpu >> 14) & 3] << 14) | (cpu & 16'h3FFF);
    exp_oe   = rd && (slot >= 0);
    exp_rd   = exp_oe ? (8'hE0 | ref_pg[slot]) : 0;
    chk(req, "phys_addr", int'(phys_addr), exp_phys);
    chk(req, "io_rdata_oe", int'(io_rdata_oe), int'(exp_oe));
    chk(req, "io_rdata", int'(io_rdata), exp_rd);
    chk("R9", "wo_oe", int'(oe_wo), 0);
    chk("R9", "wo_rdata", int'(rdata_wo), 0);
    chk(req, "wo_phys", int'(phys_wo), exp_phys);
    @(posedge clk);
    if (wr && slot >= 0) ref_pg[slot] = wd & 8'h1F;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; io_wr = 1'b0; io_rd = 1'b0;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 4; i++) ref_pg[i] = 3 - i;
  endtask

  task automatic check_boot();
    for (int q = 0; q < 4; q++) step((q << 14) | 16'h0123, 0, 1'b0, 1'b0, 0, "R1");
    for (int k = 0; k < 4; k++) step(16'h2000, 16'h00FC + k, 1'b0, 1'b1, 0, "R1");
  endtask

  initial begin : watchdog
    #(200000 * 8);
    if (!done) begin
      fails++;
      $display("FAIL watchdog all-requirements actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : main
    do_reset();
    check_boot();

    // R3/R4: load every quarter, upper data bits set on some writes
    step(0, 16'h00FC, 1'b1, 1'b0, 8'hE7, "R4");
    step(16'h0ABC, 0, 1'b0, 1'b0, 0, "R3");
    step(0, 16'h00FD, 1'b1, 1'b0, 8'h1A, "R3");
    step(16'h4001, 0, 1'b0, 1'b0, 0, "R3");
    step(0, 16'h00FE, 1'b1, 1'b0, 8'hA5, "R4");
    step(16'h8FFF, 16'h00FE, 1'b0, 1'b1, 0, "R4");
    step(0, 16'h00FF, 1'b1, 1'b0, 8'h1F, "R3");
    step(16'hFFFF, 0, 1'b0, 1'b0, 0, "R3");

    // R2: address sweep across all quarters
    for (int i = 0; i < 16; i++) step(i * 16'h1111, 0, 1'b0, 1'b0, 0, "R2");
    step(16'h3FFF, 0, 1'b0, 1'b0, 0, "R2");
    step(16'hC000, 0, 1'b0, 1'b0, 0, "R2");

    // R5: upper I/O byte ignored; foreign low bytes do nothing
    step(0, 16'h12FD, 1'b1, 1'b0, 8'h0C, "R5");
    step(16'h7777, 16'h00FD, 1'b0, 1'b1, 0, "R5");
    step(0, 16'h00FB, 1'b1, 1'b0, 8'h11, "R5");
    step(0, 16'hFC00, 1'b1, 1'b0, 8'h12, "R5");
    for (int k = 0; k < 4; k++) step(k << 14, 16'h00FC + k, 1'b0, 1'b1, 0, "R5");

    // R6: decoded address without the write strobe
    step(0, 16'h00FE, 1'b0, 1'b0, 8'h09, "R6");
    step(16'h8000, 16'h00FE, 1'b0, 1'b1, 0, "R6");

    // R7: read-back of every register, upper I/O byte nonzero
    for (int k = 0; k < 4; k++) step(16'h1234, 16'hAB00 | (16'h00FC + k), 1'b0, 1'b1, 0, "R7");

    // R8: reads outside the port block, and strobe low
    step(0, 16'h00FB, 1'b0, 1'b1, 0, "R8");
    step(0, 16'h0100, 1'b0, 1'b1, 0, "R8");
    step(0, 16'h00FC, 1'b0, 1'b0, 0, "R8");

    // R10: read and write same port in one cycle
    step(16'hC123, 16'h00FF, 1'b1, 1'b1, 8'h02, "R10");
    step(16'hC123, 16'h00FF, 1'b0, 1'b1, 0, "R10");

    // R1: reset in mid-run restores the boot pages
    step(0, 16'h00FC, 1'b1, 1'b0, 8'h15, "R3");
    do_reset();
    check_boot();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule